// File: doc/BRIEF.md
# Maskable Interrupt Controller with Acceptance Sequencer

This block is the interrupt unit of a small 8-bit microcontroller. It serves seven interrupt sources: two external pins, two timers, an ADC, a watchdog and a basic interval timer. Each source has a request flag and an enable bit. Software reaches them through a byte-wide register bus as two enable registers and two flag registers. A single-cycle event pulse from a source sets its flag. The flag stays set until the interrupt is taken, until software writes it, or until reset.

A source is eligible when its flag and its enable bit are both 1. A master interrupt flag (the I-flag) gates all eligible sources at once. When the CPU reports the end of an instruction while the I-flag is set and a source is eligible, the block runs an eight-cycle acceptance sequence on behalf of the CPU, in this order:

- It drops the I-flag.
- It clears the flag of the winning source.
- It writes the return address and the status word to the stack in three writes, decrementing the stack pointer after each write.
- It reads a two-byte vector for the winning source.
- It presents the service-routine address together with a load strobe.

A return-from-interrupt strobe restores the I-flag from the status byte the CPU has popped.

Top module: `mcu_irq_unit`

## Requirements
- R1: After reset, every enable bit, every request flag and the I-flag are 0. `busy_o` is 0 and all four registers read 0x00.
- R2: The enable registers are at 0xE2 and 0xE3, and the flag registers at 0xE4 and 0xE5. At 0xE2 and 0xE4, bits 7..4 belong to INT0, INT1, T0 and T1, in that order. At 0xE3 and 0xE5, bits 7..5 belong to ADC, WDT and BIT. All these bits can be written and read back. Unused bits read 0.
- R3: Source index i (0 = INT0 through 6 = BIT) sets its flag on a one-cycle pulse of `src_evt_i[i]`. The flag holds until the source is accepted, is written by software, or is cleared by reset. If a hardware set and a software clear fall on the same edge, the flag ends set.
- R4: A sequence starts at the edge that closes a cycle meeting all of these conditions: `insn_done_i` is 1, the block is idle, the I-flag is 1, `reti_i` is 0, and at least one source has both its flag and its enable set. Otherwise no sequence starts.
- R5: When several sources are eligible, the lowest index is accepted (INT0 highest, BIT lowest). All other flags stay set.
- R6: Counting the `insn_done_i` cycle as cycle 1, the I-flag reads 0 from cycle 2. The accepted flag reads 0 from cycle 3.
- R7: In cycles 3, 4 and 5, `stk_we_o` is 1. The writes go to addresses SP, SP-1 and SP-2, where SP is `sp_i` sampled in cycle 1. The data written is PC[15:8], then PC[7:0], then the status byte with bit 2 forced to 1. `sp_o` drops by one after each write and ends at SP-3.
- R8: In cycles 6 and 7, `vec_rd_o` is 1 with `vec_addr_o` equal to 0xFFE0 + 2*index and then +1. The bytes read are the low and high halves of the entry address. In cycle 8, `pc_load_o` is 1 with `pc_new_o` = {high, low}. `busy_o` is 1 in cycles 2 to 8 only.
- R9: While idle, `reti_i` loads the I-flag from bit 2 of `reti_psw_i`. While busy, `reti_i` and `insn_done_i` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| src_evt_i | input | 7 | Source event pulses, index 0 = INT0 ... 6 = BIT |
| insn_done_i | input | 1 | Current instruction completes this cycle |
| pc_i | input | 16 | Return address to push |
| psw_i | input | 8 | Status word to push |
| sp_i | input | 8 | Stack pointer at acceptance |
| reti_i | input | 1 | Return-from-interrupt strobe |
| reti_psw_i | input | 8 | Status byte popped by the return |
| i_flag_o | output | 1 | Master interrupt flag |
| busy_o | output | 1 | Acceptance sequence running |
| stk_we_o | output | 1 | Stack write strobe |
| stk_addr_o | output | 8 | Stack write address |
| stk_wdata_o | output | 8 | Stack write data |
| sp_o | output | 8 | Stack pointer after the pushes |
| vec_rd_o | output | 1 | Vector table read strobe |
| vec_addr_o | output | 16 | Vector table address |
| vec_data_i | input | 8 | Vector table data, same cycle |
| pc_load_o | output | 1 | Load `pc_new_o` into the PC |
| pc_new_o | output | 16 | Service routine entry address |

## Verification
The bench runs the acceptance sequence for every single source and for every pair of pending sources. A single source alone checks the flag position, the vector address and the stack bytes for that source. A pair shows whether the priority picks the lower index and whether the losing flag survives. The blocking paths are tested separately: a disabled source, a cleared I-flag, and a missing instruction-end strobe must each leave the block idle. A full byte sweep over all four registers separates the mapped bits from the unused ones. Two collision cases are covered: a return strobe arriving mid-sequence, and an event that coincides with a software clear.

// File: rtl/mic_pkg.sv
package mic_pkg;
  localparam int NSRC  = 7;
  localparam int N_HI  = 4;
  localparam int IDX_W = $clog2(NSRC);

  typedef enum logic [2:0] {
    ST_IDLE, ST_CLRF, ST_PCH, ST_PCL, ST_PSW, ST_VLO, ST_VHI, ST_LOAD
  } seq_st_e;
endpackage

// File: rtl/mic_regs.sv
module mic_regs
  import mic_pkg::*;
#(
  parameter int             AW       = 8,
  parameter int             DW       = 8,
  parameter logic [AW-1:0]  ADDR_ENH = 8'hE2,
  parameter logic [AW-1:0]  ADDR_ENL = 8'hE3,
  parameter logic [AW-1:0]  ADDR_FLH = 8'hE4,
  parameter logic [AW-1:0]  ADDR_FLL = 8'hE5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic [NSRC-1:0]  evt_i,
  input  logic             clr_i,
  input  logic [IDX_W-1:0] clr_idx_i,
  output logic [NSRC-1:0]  en_o,
  output logic [NSRC-1:0]  flag_o
);
  logic [NSRC-1:0] en_q, flag_q;
  logic [DW-1:0]   rd_enh, rd_enl, rd_flh, rd_fll;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      flag_q <= '0;
    end else begin
      for (int i = 0; i < NSRC; i++) begin
        if (i < N_HI) begin
          if (wr_i && addr_i == ADDR_ENH) en_q[i] <= wdata_i[DW-1-i];
        end else begin
          if (wr_i && addr_i == ADDR_ENL) en_q[i] <= wdata_i[DW-1-(i-N_HI)];
        end
        // hardware set has the last word so no event is lost
        if (evt_i[i])
          flag_q[i] <= 1'b1;
        else if (clr_i && clr_idx_i == IDX_W'(i))
          flag_q[i] <= 1'b0;
        else if (i < N_HI && wr_i && addr_i == ADDR_FLH)
          flag_q[i] <= wdata_i[DW-1-i];
        else if (i >= N_HI && wr_i && addr_i == ADDR_FLL)
          flag_q[i] <= wdata_i[DW-1-(i-N_HI)];
      end
    end
  end

  always_comb begin
    rd_enh = '0;
    rd_enl = '0;
    rd_flh = '0;
    rd_fll = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (i < N_HI) begin
        rd_enh[DW-1-i] = en_q[i];
        rd_flh[DW-1-i] = flag_q[i];
      end else begin
        rd_enl[DW-1-(i-N_HI)] = en_q[i];
        rd_fll[DW-1-(i-N_HI)] = flag_q[i];
      end
    end
  end

  always_comb begin
    unique case (addr_i)
      ADDR_ENH: rdata_o = rd_enh;
      ADDR_ENL: rdata_o = rd_enl;
      ADDR_FLH: rdata_o = rd_flh;
      ADDR_FLL: rdata_o = rd_fll;
      default:  rdata_o = '0;
    endcase
  end

  assign en_o   = en_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/mic_prio.sv
module mic_prio
  import mic_pkg::*;
(
  input  logic [NSRC-1:0]  req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  // scan downward so the lowest index wins
  always_comb begin
    idx_o = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/mic_seq.sv
module mic_seq
  import mic_pkg::*;
#(
  parameter int              DW        = 8,
  parameter int              PC_W      = 16,
  parameter logic [PC_W-1:0] VEC_BASE  = 16'hFFE0,
  parameter int              IFLAG_BIT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             insn_done_i,
  input  logic             any_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [DW-1:0]    psw_i,
  input  logic [DW-1:0]    sp_i,
  input  logic             reti_i,
  input  logic [DW-1:0]    reti_psw_i,
  input  logic [DW-1:0]    vec_data_i,
  output logic             busy_o,
  output logic             i_flag_o,
  output logic             clr_o,
  output logic [IDX_W-1:0] clr_idx_o,
  output logic             stk_we_o,
  output logic [DW-1:0]    stk_addr_o,
  output logic [DW-1:0]    stk_wdata_o,
  output logic [DW-1:0]    sp_o,
  output logic             vec_rd_o,
  output logic [PC_W-1:0]  vec_addr_o,
  output logic             pc_load_o,
  output logic [PC_W-1:0]  pc_new_o
);
  localparam logic [DW-1:0] IMASK = DW'(1) << IFLAG_BIT;

  seq_st_e          st_q;
  logic             i_flag_q;
  logic [IDX_W-1:0] idx_q;
  logic [PC_W-1:0]  pc_q;
  logic [DW-1:0]    psw_q, sp_q, vec_lo_q, vec_hi_q;
  logic             accept;

  assign accept = (st_q == ST_IDLE) && insn_done_i && any_i && i_flag_q && !reti_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      i_flag_q <= 1'b0;
      idx_q    <= '0;
      pc_q     <= '0;
      psw_q    <= '0;
      sp_q     <= '0;
      vec_lo_q <= '0;
      vec_hi_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (accept) begin
            st_q     <= ST_CLRF;
            i_flag_q <= 1'b0;
            idx_q    <= idx_i;
            pc_q     <= pc_i;
            psw_q    <= psw_i | IMASK;
            sp_q     <= sp_i;
          end else if (reti_i) begin
            i_flag_q <= reti_psw_i[IFLAG_BIT];
          end
        end
        ST_CLRF: st_q <= ST_PCH;
        ST_PCH: begin
          st_q <= ST_PCL;
          sp_q <= sp_q - DW'(1);
        end
        ST_PCL: begin
          st_q <= ST_PSW;
          sp_q <= sp_q - DW'(1);
        end
        ST_PSW: begin
          st_q <= ST_VLO;
          sp_q <= sp_q - DW'(1);
        end
        ST_VLO: begin
          st_q     <= ST_VHI;
          vec_lo_q <= vec_data_i;
        end
        ST_VHI: begin
          st_q     <= ST_LOAD;
          vec_hi_q <= vec_data_i;
        end
        ST_LOAD: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (st_q)
      ST_PCH:  stk_wdata_o = pc_q[PC_W-1:DW];
      ST_PCL:  stk_wdata_o = pc_q[DW-1:0];
      ST_PSW:  stk_wdata_o = psw_q;
      default: stk_wdata_o = '0;
    endcase
  end

  assign busy_o     = (st_q != ST_IDLE);
  assign i_flag_o   = i_flag_q;
  assign clr_o      = (st_q == ST_CLRF);
  assign clr_idx_o  = idx_q;
  assign stk_we_o   = (st_q == ST_PCH) || (st_q == ST_PCL) || (st_q == ST_PSW);
  assign stk_addr_o = sp_q;
  assign sp_o       = sp_q;
  assign vec_rd_o   = (st_q == ST_VLO) || (st_q == ST_VHI);
  assign vec_addr_o = VEC_BASE + PC_W'({idx_q, 1'b0}) + PC_W'(st_q == ST_VHI);
  assign pc_load_o  = (st_q == ST_LOAD);
  assign pc_new_o   = {vec_hi_q, vec_lo_q};
endmodule

// File: rtl/mcu_irq_unit.sv
module mcu_irq_unit
  import mic_pkg::*;
#(
  parameter int                 AW        = 8,
  parameter int                 DW        = 8,
  parameter logic [AW-1:0]      ADDR_ENH  = 8'hE2,
  parameter logic [AW-1:0]      ADDR_ENL  = 8'hE3,
  parameter logic [AW-1:0]      ADDR_FLH  = 8'hE4,
  parameter logic [AW-1:0]      ADDR_FLL  = 8'hE5,
  parameter logic [2*DW-1:0]    VEC_BASE  = 16'hFFE0,
  parameter int                 IFLAG_BIT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [AW-1:0]     reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  input  logic [NSRC-1:0]   src_evt_i,
  input  logic              insn_done_i,
  input  logic [2*DW-1:0]   pc_i,
  input  logic [DW-1:0]     psw_i,
  input  logic [DW-1:0]     sp_i,
  input  logic              reti_i,
  input  logic [DW-1:0]     reti_psw_i,
  output logic              i_flag_o,
  output logic              busy_o,
  output logic              stk_we_o,
  output logic [DW-1:0]     stk_addr_o,
  output logic [DW-1:0]     stk_wdata_o,
  output logic [DW-1:0]     sp_o,
  output logic              vec_rd_o,
  output logic [2*DW-1:0]   vec_addr_o,
  input  logic [DW-1:0]     vec_data_i,
  output logic              pc_load_o,
  output logic [2*DW-1:0]   pc_new_o
);
  localparam int PC_W = 2 * DW;

  logic [NSRC-1:0]  en, flag;
  logic             any;
  logic [IDX_W-1:0] win_idx, clr_idx;
  logic             clr;

  mic_regs #(
    .AW(AW), .DW(DW),
    .ADDR_ENH(ADDR_ENH), .ADDR_ENL(ADDR_ENL),
    .ADDR_FLH(ADDR_FLH), .ADDR_FLL(ADDR_FLL)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (reg_wr_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .evt_i     (src_evt_i),
    .clr_i     (clr),
    .clr_idx_i (clr_idx),
    .en_o      (en),
    .flag_o    (flag)
  );

  mic_prio u_prio (
    .req_i (flag & en),
    .any_o (any),
    .idx_o (win_idx)
  );

  mic_seq #(
    .DW(DW), .PC_W(PC_W), .VEC_BASE(VEC_BASE), .IFLAG_BIT(IFLAG_BIT)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .insn_done_i (insn_done_i),
    .any_i       (any),
    .idx_i       (win_idx),
    .pc_i        (pc_i),
    .psw_i       (psw_i),
    .sp_i        (sp_i),
    .reti_i      (reti_i),
    .reti_psw_i  (reti_psw_i),
    .vec_data_i  (vec_data_i),
    .busy_o      (busy_o),
    .i_flag_o    (i_flag_o),
    .clr_o       (clr),
    .clr_idx_o   (clr_idx),
    .stk_we_o    (stk_we_o),
    .stk_addr_o  (stk_addr_o),
    .stk_wdata_o (stk_wdata_o),
    .sp_o        (sp_o),
    .vec_rd_o    (vec_rd_o),
    .vec_addr_o  (vec_addr_o),
    .pc_load_o   (pc_load_o),
    .pc_new_o    (pc_new_o)
  );
endmodule

// File: rtl/mcu_irq_unit_chk.sv
module mcu_irq_unit_chk #(
  parameter int DW        = 8,
  parameter int IFLAG_BIT = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          i_flag_o,
  input logic          busy_o,
  input logic          stk_we_o,
  input logic [DW-1:0] stk_addr_o,
  input logic [DW-1:0] sp_o,
  input logic          vec_rd_o,
  input logic          pc_load_o,
  input logic          reti_i,
  input logic [DW-1:0] reti_psw_i
);
  a_r4_start_needs_iflag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(i_flag_o));

  a_r6_iflag_low_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !i_flag_o);

  a_r7_sp_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stk_we_o |=> (sp_o == DW'($past(stk_addr_o) - DW'(1))));

  a_r8_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({stk_we_o, vec_rd_o, pc_load_o}));

  a_r8_strobe_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stk_we_o || vec_rd_o || pc_load_o) |-> busy_o);

  a_r8_load_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_o |=> !busy_o);

  a_r9_reti_restore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && !busy_o) |=> (i_flag_o == $past(reti_psw_i[IFLAG_BIT])));
endmodule

bind mcu_irq_unit mcu_irq_unit_chk #(.DW(DW), .IFLAG_BIT(IFLAG_BIT)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .i_flag_o   (i_flag_o),
  .busy_o     (busy_o),
  .stk_we_o   (stk_we_o),
  .stk_addr_o (stk_addr_o),
  .sp_o       (sp_o),
  .vec_rd_o   (vec_rd_o),
  .pc_load_o  (pc_load_o),
  .reti_i     (reti_i),
  .reti_psw_i (reti_psw_i)
);

// File: tb/mcu_irq_unit_test.sv
module mcu_irq_unit_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [7:0]  reg_addr_i = 8'h00;
  logic [7:0]  reg_wdata_i = 8'h00;
  logic [7:0]  reg_rdata_o;
  logic [6:0]  src_evt_i = '0;
  logic        insn_done_i = 1'b0;
  logic [15:0] pc_i = '0;
  logic [7:0]  psw_i = '0;
  logic [7:0]  sp_i = '0;
  logic        reti_i = 1'b0;
  logic [7:0]  reti_psw_i = '0;
  logic        i_flag_o, busy_o, stk_we_o, vec_rd_o, pc_load_o;
  logic [7:0]  stk_addr_o, stk_wdata_o, sp_o, vec_data_i;
  logic [15:0] vec_addr_o, pc_new_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  // vector table model: byte at address a is a[7:0] ^ 8'hA5
  assign vec_data_i = vec_addr_o[7:0] ^ 8'hA5;

  mcu_irq_unit uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    step();
    reg_wr_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    reg_addr_i = a;
    #1;
    chk(req, reg_rdata_o, exp);
  endtask

  task automatic pulse(input logic [6:0] m);
    src_evt_i = m;
    step();
    src_evt_i = '0;
  endtask

  task automatic set_i(input bit v);
    reti_i = 1'b1;
    reti_psw_i = v ? 8'h04 : 8'hFB;
    step();
    reti_i = 1'b0;
    #1;
    chk("R9 reti restore", i_flag_o, v);
  endtask

  function automatic logic [7:0] fl_addr(input int i);
    return (i < 4) ? 8'hE4 : 8'hE5;
  endfunction

  function automatic logic [7:0] fl_bit(input int i);
    return (i < 4) ? 8'(8'h80 >> i) : 8'(8'h80 >> (i - 4));
  endfunction

  task automatic run_accept(input int idx, input logic [15:0] pc, input logic [7:0] psw,
                            input logic [7:0] sp, input bit inj);
    logic [15:0] va;
    va = 16'hFFE0 + 16'(2 * idx);
    insn_done_i = 1'b1; pc_i = pc; psw_i = psw; sp_i = sp;
    step();
    insn_done_i = 1'b0;
    #1;
    chk("R8 busy cycle2", busy_o, 1);
    chk("R6 iflag cleared", i_flag_o, 0);
    chk("R7 no write cycle2", stk_we_o, 0);
    step();
    if (inj) begin
      reti_i = 1'b1; reti_psw_i = 8'hFF; insn_done_i = 1'b1;
    end
    reg_addr_i = fl_addr(idx);
    #1;
    chk("R6 accepted flag cleared", reg_rdata_o & fl_bit(idx), 0);
    chk("R7 push pch we", stk_we_o, 1);
    chk("R7 push pch addr", stk_addr_o, sp);
    chk("R7 push pch data", stk_wdata_o, pc[15:8]);
    step();
    reti_i = 1'b0; insn_done_i = 1'b0;
    #1;
    chk("R7 push pcl addr", stk_addr_o, 8'(sp - 1));
    chk("R7 push pcl data", stk_wdata_o, pc[7:0]);
    step();
    #1;
    chk("R7 push psw addr", stk_addr_o, 8'(sp - 2));
    chk("R7 push psw data", stk_wdata_o, psw | 8'h04);
    step();
    #1;
    chk("R7 write stops", stk_we_o, 0);
    chk("R8 vec lo rd", vec_rd_o, 1);
    chk("R8 vec lo addr", vec_addr_o, va);
    step();
    #1;
    chk("R8 vec hi addr", vec_addr_o, va + 16'd1);
    step();
    #1;
    chk("R8 pc load", pc_load_o, 1);
    chk("R8 pc value", pc_new_o, {8'(va[7:0] + 8'd1) ^ 8'hA5, va[7:0] ^ 8'hA5});
    step();
    #1;
    chk("R8 idle after", busy_o, 0);
    chk("R8 load one cycle", pc_load_o, 0);
    chk("R7 sp final", sp_o, 8'(sp - 3));
    if (inj) chk("R9 reti ignored while busy", i_flag_o, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R8 watchdog act=timeout exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step();
    step();
    // R1 reset state
    chk("R1 busy reset", busy_o, 0);
    chk("R1 iflag reset", i_flag_o, 0);
    rd_chk("R1 enh reset", 8'hE2, 8'h00);
    rd_chk("R1 enl reset", 8'hE3, 8'h00);
    rd_chk("R1 flh reset", 8'hE4, 8'h00);
    rd_chk("R1 fll reset", 8'hE5, 8'h00);
    rst_ni = 1'b1;
    step();

    // R2 full byte sweep on each register
    for (int d = 0; d < 256; d++) begin
      wr(8'hE2, 8'(d)); rd_chk("R2 enh rw", 8'hE2, 8'(d) & 8'hF0);
      wr(8'hE3, 8'(d)); rd_chk("R2 enl rw", 8'hE3, 8'(d) & 8'hE0);
      wr(8'hE4, 8'(d)); rd_chk("R2 flh rw", 8'hE4, 8'(d) & 8'hF0);
      wr(8'hE5, 8'(d)); rd_chk("R2 fll rw", 8'hE5, 8'(d) & 8'hE0);
      rd_chk("R2 unmapped reads 0", 8'hE6, 8'h00);
    end
    wr(8'hE2, 8'h00); wr(8'hE3, 8'h00); wr(8'hE4, 8'h00); wr(8'hE5, 8'h00);

    // R3 event sets flag, holds, software clears
    for (int i = 0; i < 7; i++) begin
      pulse(7'(1 << i));
      repeat (3) step();
      rd_chk("R3 flag set hi", 8'hE4, (i < 4) ? fl_bit(i) : 8'h00);
      rd_chk("R3 flag set lo", 8'hE5, (i < 4) ? 8'h00 : fl_bit(i));
      wr(fl_addr(i), 8'h00);
      rd_chk("R3 sw clear", fl_addr(i), 8'h00);
    end
    // R3 hardware set beats simultaneous software clear
    src_evt_i = 7'b0000010;
    wr(8'hE4, 8'h00);
    src_evt_i = '0;
    rd_chk("R3 hw set wins", 8'hE4, 8'h40);
    wr(8'hE4, 8'h00);

    // R4 blocked cases
    pulse(7'b0000001);
    set_i(1'b1);
    insn_done_i = 1'b1; step(); insn_done_i = 1'b0; #1;
    chk("R4 disabled source no start", busy_o, 0);
    wr(8'hE2, 8'h80);
    set_i(1'b0);
    insn_done_i = 1'b1; step(); insn_done_i = 1'b0; #1;
    chk("R4 iflag 0 no start", busy_o, 0);
    set_i(1'b1);
    repeat (3) step();
    chk("R4 no insn_done no start", busy_o, 0);
    rd_chk("R4 flag still pending", 8'hE4, 8'h80);
    wr(8'hE4, 8'h00);

    // R5..R8 every single source and every pair
    wr(8'hE2, 8'hF0); wr(8'hE3, 8'hE0);
    for (int i = 0; i < 7; i++) begin
      for (int j = i; j < 7; j++) begin
        pulse(7'((1 << i) | (1 << j)));
        set_i(1'b1);
        run_accept(i, 16'h1234 + 16'(i * 16'h0101) + 16'(j), 8'(i * 16 + j) & 8'hFB,
                   8'(8'h80 + i * 8 + j), (i == 2 && j == 5));
        if (j != i) begin
          rd_chk("R5 loser flag kept", fl_addr(j), fl_bit(j));
          wr(fl_addr(j), 8'h00);
        end
        rd_chk("R5 flags clear hi", 8'hE4, 8'h00);
        rd_chk("R5 flags clear lo", 8'hE5, 8'h00);
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule